// File: doc/BRIEF.md
# SCL Timing Generator for an I2C Master

This block produces the SCL waveform for an I2C master. The peripheral clock first passes through a prescaler, which makes an internal tick once every `CDF + 1` peripheral-clock cycles. A phase counter then splits each SCL period into a driven-low half and a released half. Each half lasts `10 + 4*SCGD` internal ticks, so the base period is `20 + 8*SCGD` ticks. Both divisor fields come in on one configuration word. The low field is `CDF` and the field directly above it is `SCGD`.

The released half does not begin to count when the block lets go of SCL. It begins only once the sensed line, after a synchronizer, reads high. The rise time, the synchronizer delay and any low hold by a slave are therefore added to the period. The bit engine receives a one-cycle strobe at each boundary between halves. Whenever the interface enable is clear, the block is held at rest. In that state SCL is released and the configuration word is sampled.

Top module: `scl_clock_divider`

## Requirements
- R1: While `enable` is low (and during reset), `scl_drive_low` and `half_strobe` are both 0. The first rising clock edge that sees `enable` high makes `scl_drive_low` 1.
- R2: The configuration word is packed as `div_cfg[CDF_W-1:0]` = CDF and `div_cfg[CDF_W+SCGD_W-1:CDF_W]` = SCGD.
- R3: The internal tick repeats every `CDF + 1` clock cycles and restarts at the start of each counted half, so every counted half lasts a whole multiple of `CDF + 1` cycles.
- R4: Each driven-low half lasts exactly `(10 + 4*SCGD) * (CDF + 1)` clock cycles.
- R5: Each released half lasts `(10 + 4*SCGD) * (CDF + 1) + SYNC_STAGES + 1 + S` clock cycles. Here S is the number of cycles that `scl_in` stays low after the release. The count does not advance while the synchronized line reads low.
- R6: `half_strobe` is a one-cycle pulse that falls in the first cycle of every released half and of every driven-low half that follows a released half. The first driven-low half after enable carries no pulse.
- R7: `div_cfg` is sampled only while `enable` is low. A change made while enabled has no effect on the waveform until the next disable/enable cycle.
- R8: Clearing `enable` releases SCL and suppresses `half_strobe` from the next clock edge on, whatever the phase.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on `clk` |
| enable | input | 1 | Master interface enable; low holds the divider at rest |
| div_cfg | input | CDF_W+SCGD_W | Packed divisor word {SCGD, CDF} |
| scl_in | input | 1 | Sensed level of the SCL line |
| scl_drive_low | output | 1 | 1 = pull SCL low, 0 = release |
| half_strobe | output | 1 | One-cycle pulse at each half-period boundary |

## Verification
The hardest case to reach from the ports is a released half whose length depends on the line and not on the counter. The stimulus gets there through a bench model of the wire. This model follows `scl_drive_low` and can keep the line low for a chosen number of cycles after each release, acting like a slave that stretches the clock. The bench sweeps every CDF and SCGD value of a small configuration, with and without this hold. It also changes the configuration word in the middle of a run and drops the enable inside both halves. This confirms that the latched divisors stay in force and that the release takes effect on the next edge.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_WAIT = 2'd2,
      PH_HIGH = 2'd3
   } scl_phase_e;

   localparam int unsigned HALF_BASE = 10;
   localparam int unsigned HALF_STEP_SHIFT = 2;

endpackage

// File: rtl/scl_div_prescale.sv
module scl_div_prescale #(
   parameter int unsigned CDF_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             restart,
   input  logic [CDF_W-1:0] cdf,
   output logic             tick
);

   logic [CDF_W-1:0] pre_q;

   assign tick = (pre_q == cdf);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (!enable || restart || tick) begin
         pre_q <= '0;
      end else begin
         pre_q <= pre_q + 1'b1;
      end
   end

   // R3: the prescale count never passes the divisor
   a_r3_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
      pre_q <= cdf);

   // R3: a restart always brings the count back to its origin
   a_r3_restart_origin: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && restart) |=> (pre_q == '0));

endmodule

// File: rtl/scl_div_sync.sv
module scl_div_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] st_q;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) st_q[g] <= 1'b1;
            else        st_q[g] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) st_q[g] <= 1'b1;
            else        st_q[g] <= st_q[g-1];
         end
      end
   end

   assign q = st_q[STAGES-1];

endmodule

// File: rtl/scl_div_phase.sv
module scl_div_phase
   import scl_div_pkg::*;
#(
   parameter int unsigned SCGD_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              tick,
   input  logic              scl_seen,
   input  logic [SCGD_W-1:0] scgd,
   output logic              restart,
   output logic              drive_low,
   output logic              strobe
);

   localparam int unsigned HALF_W = SCGD_W + 4;

   scl_phase_e        state_q, state_d;
   logic [HALF_W-1:0] cnt_q, cnt_d;
   logic [HALF_W-1:0] half_len;
   logic              strobe_q, strobe_d;
   logic              last_tick;

   assign half_len  = HALF_W'(HALF_BASE) + HALF_W'({scgd, HALF_STEP_SHIFT'(0)});
   assign last_tick = tick && (cnt_q == half_len - 1'b1);

   always_comb begin
      state_d  = state_q;
      cnt_d    = cnt_q;
      strobe_d = 1'b0;
      restart  = 1'b0;
      unique case (state_q)
         PH_IDLE: begin
            state_d = PH_LOW;
            cnt_d   = '0;
            restart = 1'b1;
         end
         PH_LOW: begin
            if (last_tick) begin
               state_d  = PH_WAIT;
               cnt_d    = '0;
               strobe_d = 1'b1;
            end else if (tick) begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         PH_WAIT: begin
            if (scl_seen) begin
               state_d = PH_HIGH;
               cnt_d   = '0;
               restart = 1'b1;
            end
         end
         PH_HIGH: begin
            if (last_tick) begin
               state_d  = PH_LOW;
               cnt_d    = '0;
               strobe_d = 1'b1;
            end else if (tick) begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         default: state_d = PH_IDLE;
      endcase
      if (!enable) begin
         state_d  = PH_IDLE;
         cnt_d    = '0;
         strobe_d = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= PH_IDLE;
         cnt_q    <= '0;
         strobe_q <= 1'b0;
      end else begin
         state_q  <= state_d;
         cnt_q    <= cnt_d;
         strobe_q <= strobe_d;
      end
   end

   assign drive_low = (state_q == PH_LOW);
   assign strobe    = strobe_q;

   // R8: a cleared enable returns the phase to rest with no strobe
   a_r8_disable_release: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (state_q == PH_IDLE && !strobe_q));

   // R6: every strobe coincides with a change of the drive
   a_r6_strobe_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_q |-> (drive_low != $past(drive_low)));

   // R5: the released half does not start counting while the line reads low
   a_r5_hold_until_high: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_WAIT && !scl_seen && enable) |=> (state_q == PH_WAIT));

   // R4: the half counter stays inside the half length
   a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_LOW || state_q == PH_HIGH) |-> (cnt_q < half_len));

endmodule

// File: rtl/scl_clock_divider.sv
module scl_clock_divider #(
   parameter int unsigned CDF_W       = 3,
   parameter int unsigned SCGD_W      = 6,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      enable,
   input  logic [CDF_W+SCGD_W-1:0]   div_cfg,
   input  logic                      scl_in,
   output logic                      scl_drive_low,
   output logic                      half_strobe
);

   localparam int unsigned CFG_W = CDF_W + SCGD_W;

   if (CDF_W < 1 || CDF_W > 4) begin : g_bad_cdf_w
      $error("scl_clock_divider: CDF_W must be 1..4");
   end
   if (SCGD_W < 1 || SCGD_W > 8) begin : g_bad_scgd_w
      $error("scl_clock_divider: SCGD_W must be 1..8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("scl_clock_divider: SYNC_STAGES must be at least 2");
   end

   logic [CDF_W-1:0]  cdf_q;
   logic [SCGD_W-1:0] scgd_q;
   logic              tick;
   logic              restart;
   logic              scl_seen;

   // Divisors are captured only while the interface is at rest
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cdf_q  <= '0;
         scgd_q <= '0;
      end else if (!enable) begin
         cdf_q  <= div_cfg[CDF_W-1:0];
         scgd_q <= div_cfg[CFG_W-1:CDF_W];
      end
   end

   scl_div_prescale #(.CDF_W(CDF_W)) u_prescale (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (enable),
      .restart (restart),
      .cdf     (cdf_q),
      .tick    (tick)
   );

   scl_div_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (scl_in),
      .q     (scl_seen)
   );

   scl_div_phase #(.SCGD_W(SCGD_W)) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .tick      (tick),
      .scl_seen  (scl_seen),
      .scgd      (scgd_q),
      .restart   (restart),
      .drive_low (scl_drive_low),
      .strobe    (half_strobe)
   );

   // R7: latched divisors hold steady for as long as the interface stays enabled
   a_r7_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && $past(enable)) |-> ($stable(cdf_q) && $stable(scgd_q)));

   // R1: nothing is driven and no strobe is given while disabled
   a_r1_rest_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !$past(enable)) |-> (!scl_drive_low && !half_strobe));

endmodule

// File: tb/scl_clock_divider_test.sv
module scl_clock_divider_test;

   localparam int CDF_W  = 2;
   localparam int SCGD_W = 3;
   localparam int SYNC   = 2;
   localparam int CFG_W  = CDF_W + SCGD_W;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             enable;
   logic [CFG_W-1:0] div_cfg;
   logic             scl_line;
   logic             scl_drive_low;
   logic             half_strobe;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   int stretch = 0;
   int rel_cnt = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   scl_clock_divider #(.CDF_W(CDF_W), .SCGD_W(SCGD_W), .SYNC_STAGES(SYNC)) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .enable        (enable),
      .div_cfg       (div_cfg),
      .scl_in        (scl_line),
      .scl_drive_low (scl_drive_low),
      .half_strobe   (half_strobe)
   );

   // Wire model: open-drain line, optionally held low by a slave after release
   always @(posedge clk) begin
      if (scl_drive_low) rel_cnt <= 0;
      else if (rel_cnt < 100000) rel_cnt <= rel_cnt + 1;
   end
   assign scl_line = !scl_drive_low && (rel_cnt >= stretch);

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc >= 190000 && !done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog (all requirements) actual=%0d expected<190000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_len(input logic lvl, output int n, output int strobes, output int first_st);
      n = 0;
      strobes = 0;
      first_st = 0;
      while (scl_drive_low == lvl && n < 5000) begin
         if (half_strobe) strobes++;
         if (n == 0) first_st = int'(half_strobe);
         n++;
         @(negedge clk);
      end
   endtask

   function automatic int half_cycles(input int cdf, input int scgd);
      return (10 + 4 * scgd) * (cdf + 1);
   endfunction

   task automatic start_cfg(input int cdf, input int scgd, input int s);
      enable  = 1'b0;
      div_cfg = {SCGD_W'(scgd), CDF_W'(cdf)};
      stretch = s;
      repeat (3) @(negedge clk);
      check("R1 rest drive", int'(scl_drive_low), 0);
      check("R1 rest strobe", int'(half_strobe), 0);
      enable = 1'b1;
      @(negedge clk);
      check("R1 low on first enabled edge", int'(scl_drive_low), 1);
   endtask

   task automatic measure(input int cdf, input int scgd, input int s);
      int n, st, fs;
      run_len(1'b1, n, st, fs);
      check("R4 first low half", n, half_cycles(cdf, scgd));
      check("R6 no strobe in first low", st, 0);
      run_len(1'b0, n, st, fs);
      check("R5 released half", n, half_cycles(cdf, scgd) + SYNC + 1 + s);
      check("R6 strobe at release", st * 10 + fs, 11);
      run_len(1'b1, n, st, fs);
      check("R4 second low half", n, half_cycles(cdf, scgd));
      check("R6 strobe at drive", st * 10 + fs, 11);
   endtask

   initial begin
      rst_n   = 1'b0;
      enable  = 1'b0;
      div_cfg = '0;
      repeat (4) @(negedge clk);
      check("R1 reset drive", int'(scl_drive_low), 0);
      check("R1 reset strobe", int'(half_strobe), 0);
      rst_n = 1'b1;

      // R2 R3 R4 R5 R6: exhaustive divisor sweep, with and without a slave hold
      for (int s = 0; s <= 7; s += 7) begin
         for (int cdf = 0; cdf < (1 << CDF_W); cdf++) begin
            for (int scgd = 0; scgd < (1 << SCGD_W); scgd++) begin
               start_cfg(cdf, scgd, s);
               measure(cdf, scgd, s);
            end
         end
      end

      // R5: long clock stretch
      start_cfg(0, 0, 100);
      measure(0, 0, 100);

      // R7: change while enabled is ignored, taken after re-enable
      start_cfg(1, 2, 0);
      div_cfg = {SCGD_W'(7), CDF_W'(3)};
      measure(1, 2, 0);
      start_cfg(3, 7, 0);
      measure(3, 7, 0);

      // R8: disable inside the low half
      start_cfg(2, 3, 0);
      repeat (5) @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      check("R8 release from low", int'(scl_drive_low), 0);
      check("R8 no strobe from low", int'(half_strobe), 0);

      // R8: disable inside the released half, then stay quiet
      begin
         int n, st, fs, seen;
         start_cfg(1, 1, 0);
         run_len(1'b1, n, st, fs);
         repeat (6) @(negedge clk);
         enable = 1'b0;
         @(negedge clk);
         seen = 0;
         for (int k = 0; k < 40; k++) begin
            if (scl_drive_low || half_strobe) seen++;
            @(negedge clk);
         end
         check("R8 quiet after disable in high", seen, 0);
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule